// File: doc/BRIEF.md
# Multiplexed Bus I/O and Configuration Target

This block is the responding side of a 32-bit shared address/data bus with active-low handshakes. It watches the cycle-start line and takes the first clock in which it sees that line low as the address phase. In that clock it samples the address and the 4-bit command and decides whether to answer. It answers four commands only: I/O read, I/O write, configuration read and configuration write. Everything else is left alone. After it claims a cycle it runs one or more data phases. A word moves only on a clock edge where the initiator-ready and target-ready lines are both low.

A small header register file holds the configuration space. It has identity fields, an I/O enable bit, one I/O window register, and an interrupt line and pin pair. I/O cycles that hit the window go to internal logic. Reads use a strobe, with the data returned in the same cycle. Writes produce a one-cycle strobe that carries the data and active-high byte lanes. The block drives read data with even parity and the usual claim, ready and stop lines. Each driven line has an output enable, so the pads can be tri-stated.

Back-pressure works only through the handshake. The initiator holds off with the initiator-ready line. The target inserts exactly one wait state before each read word and none on writes. I/O cycles are cut to a single word by the stop line.

Top module: `iobus_target`

## Requirements
- R1: A cycle is decoded only in the first clock where `frame_n` is low after a clock where it was high, with the target idle. Later clocks of a cycle the target did not claim are never decoded as an address phase, even with a valid command on the bus.
- R2: Only commands 4'b0010 (I/O read), 4'b0011 (I/O write), 4'b1010 (configuration read) and 4'b1011 (configuration write) on `cbe_n` can be claimed. Any other code leaves `ctl_oe` low for the whole cycle.
- R3: An I/O cycle is claimed only when the I/O enable bit (bit 0 of the dword at offset 0x04) is 1 and `ad_in[31:IO_AW]` equals the window base. The byte address `ad_in[IO_AW-1:0]`, including bits 1 and 0, is presented on `io_addr`.
- R4: A configuration cycle is claimed only when `idsel` is high and `ad_in[1:0]` is 2'b00 in the address phase. `ad_in[7:2]` selects the dword.
- R5: `devsel_n` is low from the clock after the address phase through the last data phase. In the clock after the final transfer, `devsel_n` and `trdy_n` are high with `ctl_oe` still set. One clock later `ctl_oe` and `ad_oe` are low.
- R6: Data moves only at an edge where `irdy_n` and `trdy_n` are both low. While `irdy_n` is high the target holds `trdy_n` low and keeps `ad_out` stable.
- R7: Each read word is preceded by one clock with `trdy_n` high and `devsel_n` low. `ad_out` holds the word while `trdy_n` is low. `ad_oe` is low in the first such clock of a cycle and high from then until the end.
- R8: `par_out` equals the XOR of `ad_out` and `cbe_n` from the previous clock, which gives even parity. `par_oe` equals `ad_oe` from the previous clock.
- R9: An I/O data phase asserts `stop_n` together with `trdy_n`. If `frame_n` is still low after that transfer, the target holds `stop_n` and `devsel_n` low with `trdy_n` high until `frame_n` is seen high.
- R10: Configuration cycles may burst. The dword index advances by one per transferred word and `stop_n` stays high.
- R11: Configuration reads return the following values. Offset 0x00 holds {device ID, vendor ID}. Offset 0x04 holds the I/O enable in bit 0, with all other bits 0. Offset 0x08 holds {class code, revision}. Offset 0x10 holds {window base, zeros, 1'b1}. Offset 0x3C holds {16'h0, interrupt pin, interrupt line}. Every other offset reads as 0.
- R12: Configuration writes update a byte only when its lane enable (`cbe_n[k]` low) is set. Identity fields, class code and revision ignore writes.
- R13: An I/O read raises `io_rd_stb` in the wait clock before the word and captures `io_rdata` at the end of that clock. An I/O write raises `io_wr_stb` for one clock after the transfer, with `io_wdata` and `io_be` (which is `~cbe_n`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Cycle framing, low while a cycle is in progress |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration select for this target |
| ad_in | input | 32 | Address/data lines as seen from the bus |
| cbe_n | input | 4 | Command in the address phase, active-low byte lanes in data phases |
| ad_out | output | 32 | Read data driven onto the bus |
| ad_oe | output | 1 | Enable for `ad_out` |
| trdy_n | output | 1 | Target ready, active low |
| devsel_n | output | 1 | Claim indication, active low |
| stop_n | output | 1 | Stop request, active low |
| ctl_oe | output | 1 | Enable for `trdy_n`, `devsel_n` and `stop_n` |
| par_out | output | 1 | Even parity over the previous clock's data and lanes |
| par_oe | output | 1 | Enable for `par_out` |
| io_rd_stb | output | 1 | Internal I/O read strobe |
| io_wr_stb | output | 1 | Internal I/O write strobe |
| io_addr | output | IO_AW | Byte address inside the I/O window |
| io_wdata | output | 32 | Internal I/O write data |
| io_be | output | 4 | Internal I/O write byte lanes, active high |
| io_rdata | input | 32 | Internal I/O read data, valid while `io_rd_stb` is high |

## Verification
The properties assume an initiator that follows the protocol. It keeps `frame_n`, `irdy_n` and `cbe_n` at known levels after reset. It drives `cbe_n` steadily through each data clock. It raises `frame_n` once the target signals stop. The stimulus comes from tasks that act as a well-behaved initiator. Inputs change only on the falling edge. `frame_n` is raised only together with the final `irdy_n` assertion, or in the clock after a stop. Wait states are inserted only by holding `irdy_n` high. The one deliberate break from a normal cycle is a valid configuration command placed in the middle of an unclaimed cycle. That case checks that such mid-cycle traffic is never decoded.

// File: rtl/iobt_pkg.sv
package iobt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_RDATA = 3'd2,
    ST_WDATA = 3'd3,
    ST_STOP  = 3'd4,
    ST_TAIL  = 3'd5
  } iobt_state_e;

  localparam logic [2:0] CMD_IO_GRP  = 3'b001;
  localparam logic [2:0] CMD_CFG_GRP = 3'b101;

  localparam logic [5:0] IDX_IDENT = 6'h00;
  localparam logic [5:0] IDX_CMD   = 6'h01;
  localparam logic [5:0] IDX_CLASS = 6'h02;
  localparam logic [5:0] IDX_BAR0  = 6'h04;
  localparam logic [5:0] IDX_INTR  = 6'h0F;

  function automatic logic iobt_even_par(input logic [31:0] d, input logic [3:0] c);
    return ^{d, c};
  endfunction

endpackage

// File: rtl/iobt_decode.sv
module iobt_decode #(
  parameter int IO_AW = 4
) (
  input  logic [31:IO_AW] ad_hi,
  input  logic [1:0]      ad_lo,
  input  logic [3:0]      cmd,
  input  logic            idsel,
  input  logic            io_en,
  input  logic [31:IO_AW] bar_base,
  output logic            claim,
  output logic            is_io,
  output logic            is_rd
);
  import iobt_pkg::*;

  logic is_cfg;
  logic io_hit;
  logic cfg_hit;

  always_comb begin
    is_io   = (cmd[3:1] == CMD_IO_GRP);
    is_cfg  = (cmd[3:1] == CMD_CFG_GRP);
    is_rd   = ~cmd[0];
    io_hit  = io_en && (ad_hi == bar_base);
    cfg_hit = idsel && (ad_lo == 2'b00);
    claim   = (is_io && io_hit) || (is_cfg && cfg_hit);
  end

endmodule

// File: rtl/iobt_cfg_space.sv
module iobt_cfg_space #(
  parameter logic [15:0] VEN_ID     = 16'h1B2C,
  parameter logic [15:0] DEV_ID     = 16'h0A51,
  parameter logic [23:0] CLASS_CODE = 24'h078000,
  parameter logic [7:0]  REV_ID     = 8'h03,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter int          IO_AW      = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [5:0]      rd_idx,
  output logic [31:0]     rd_data,
  input  logic            wr_en,
  input  logic [5:0]      wr_idx,
  input  logic [31:0]     wr_data,
  input  logic [3:0]      wr_be,
  output logic            io_en,
  output logic [31:IO_AW] bar_base
);
  import iobt_pkg::*;

  localparam int LOW_PAD = IO_AW - 1;

  logic            io_en_q;
  logic [31:IO_AW] bar_q;
  logic [31:IO_AW] bar_nxt;
  logic [7:0]      int_line_q;

  // Per-lane merge of the window base; bits below IO_AW are fixed.
  always_comb begin
    bar_nxt = bar_q;
    for (int b = IO_AW; b < 32; b++) begin
      if (wr_be[b/8]) bar_nxt[b] = wr_data[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_en_q    <= 1'b0;
      bar_q      <= '0;
      int_line_q <= 8'h00;
    end else if (wr_en) begin
      unique case (wr_idx)
        IDX_CMD:  if (wr_be[0]) io_en_q <= wr_data[0];
        IDX_BAR0: bar_q <= bar_nxt;
        IDX_INTR: if (wr_be[0]) int_line_q <= wr_data[7:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    unique case (rd_idx)
      IDX_IDENT: rd_data = {DEV_ID, VEN_ID};
      IDX_CMD:   rd_data = {31'h0, io_en_q};
      IDX_CLASS: rd_data = {CLASS_CODE, REV_ID};
      IDX_BAR0:  rd_data = {bar_q, {LOW_PAD{1'b0}}, 1'b1};
      IDX_INTR:  rd_data = {16'h0, INT_PIN, int_line_q};
      default:   rd_data = 32'h0;
    endcase
  end

  assign io_en    = io_en_q;
  assign bar_base = bar_q;

endmodule

// File: rtl/iobt_seq.sv
module iobt_seq (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  claim_io,
  input  logic                  claim_rd,
  input  logic                  frame_n,
  input  logic                  irdy_n,
  output iobt_pkg::iobt_state_e state_q,
  output logic                  io_q,
  output logic                  rd_q,
  output logic                  first_q,
  output logic                  xfer
);
  import iobt_pkg::*;

  iobt_state_e state_d;

  assign xfer = ((state_q == ST_RDATA) || (state_q == ST_WDATA)) && !irdy_n;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = claim_rd ? ST_FETCH : ST_WDATA;
      ST_FETCH: state_d = ST_RDATA;
      ST_RDATA, ST_WDATA: begin
        if (xfer) begin
          if (frame_n)   state_d = ST_TAIL;
          else if (io_q) state_d = ST_STOP;
          else           state_d = rd_q ? ST_FETCH : ST_WDATA;
        end
      end
      ST_STOP:  if (frame_n) state_d = ST_TAIL;
      ST_TAIL:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      io_q    <= 1'b0;
      rd_q    <= 1'b0;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start) begin
        io_q    <= claim_io;
        rd_q    <= claim_rd;
        first_q <= 1'b1;
      end else if (xfer) begin
        first_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/iobus_target.sv
module iobus_target #(
  parameter logic [15:0] VEN_ID     = 16'h1B2C,
  parameter logic [15:0] DEV_ID     = 16'h0A51,
  parameter logic [23:0] CLASS_CODE = 24'h078000,
  parameter logic [7:0]  REV_ID     = 8'h03,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter int          IO_AW      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             idsel,
  input  logic [31:0]      ad_in,
  input  logic [3:0]       cbe_n,
  output logic [31:0]      ad_out,
  output logic             ad_oe,
  output logic             trdy_n,
  output logic             devsel_n,
  output logic             stop_n,
  output logic             ctl_oe,
  output logic             par_out,
  output logic             par_oe,
  output logic             io_rd_stb,
  output logic             io_wr_stb,
  output logic [IO_AW-1:0] io_addr,
  output logic [31:0]      io_wdata,
  output logic [3:0]       io_be,
  input  logic [31:0]      io_rdata
);
  import iobt_pkg::*;

  iobt_state_e     state_q;
  logic            io_q, rd_q, first_q, xfer;
  logic            frame_q;
  logic            start;
  logic            claim, dec_io, dec_rd;
  logic            io_en;
  logic [31:IO_AW] bar_base;
  logic [7:0]      addr_q;
  logic [31:0]     cfg_rdata;
  logic [31:0]     ad_out_q;
  logic            par_q, par_oe_q;
  logic            wstb_q;
  logic [31:0]     wdata_q;
  logic [3:0]      wbe_q;

  // A new address phase is only seen on a falling frame while idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= 1'b1;
    else        frame_q <= frame_n;
  end
  assign start = (state_q == ST_IDLE) && !frame_n && frame_q && claim;

  iobt_decode #(.IO_AW(IO_AW)) u_dec (
    .ad_hi    (ad_in[31:IO_AW]),
    .ad_lo    (ad_in[1:0]),
    .cmd      (cbe_n),
    .idsel    (idsel),
    .io_en    (io_en),
    .bar_base (bar_base),
    .claim    (claim),
    .is_io    (dec_io),
    .is_rd    (dec_rd)
  );

  iobt_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .claim_io (dec_io),
    .claim_rd (dec_rd),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .state_q  (state_q),
    .io_q     (io_q),
    .rd_q     (rd_q),
    .first_q  (first_q),
    .xfer     (xfer)
  );

  iobt_cfg_space #(
    .VEN_ID     (VEN_ID),
    .DEV_ID     (DEV_ID),
    .CLASS_CODE (CLASS_CODE),
    .REV_ID     (REV_ID),
    .INT_PIN    (INT_PIN),
    .IO_AW      (IO_AW)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (addr_q[7:2]),
    .rd_data  (cfg_rdata),
    .wr_en    (xfer && !io_q && !rd_q),
    .wr_idx   (addr_q[7:2]),
    .wr_data  (ad_in),
    .wr_be    (~cbe_n),
    .io_en    (io_en),
    .bar_base (bar_base)
  );

  // Address register: latched at claim, dword index steps on config bursts.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= 8'h00;
    end else if (start) begin
      addr_q <= ad_in[7:0];
    end else if (xfer && !io_q) begin
      addr_q[7:2] <= addr_q[7:2] + 6'd1;
    end
  end

  // Read word is loaded during the wait clock in front of each data phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ad_out_q <= 32'h0;
    end else if (state_q == ST_FETCH) begin
      ad_out_q <= io_q ? io_rdata : cfg_rdata;
    end
  end

  // Parity trails the bus values it covers by one clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q    <= 1'b0;
      par_oe_q <= 1'b0;
    end else begin
      par_q    <= iobt_even_par(ad_out_q, cbe_n);
      par_oe_q <= ad_oe;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wstb_q  <= 1'b0;
      wdata_q <= 32'h0;
      wbe_q   <= 4'h0;
    end else begin
      wstb_q <= xfer && io_q && !rd_q;
      if (xfer && io_q && !rd_q) begin
        wdata_q <= ad_in;
        wbe_q   <= ~cbe_n;
      end
    end
  end

  always_comb begin
    trdy_n    = !((state_q == ST_RDATA) || (state_q == ST_WDATA));
    devsel_n  = !((state_q == ST_FETCH) || (state_q == ST_RDATA) ||
                  (state_q == ST_WDATA) || (state_q == ST_STOP));
    stop_n    = !((io_q && !trdy_n) || (state_q == ST_STOP));
    ctl_oe    = (state_q != ST_IDLE);
    ad_oe     = rd_q && (state_q != ST_IDLE) && !((state_q == ST_FETCH) && first_q);
    io_rd_stb = (state_q == ST_FETCH) && io_q;
  end

  assign ad_out    = ad_out_q;
  assign par_out   = par_q;
  assign par_oe    = par_oe_q;
  assign io_wr_stb = wstb_q;
  assign io_wdata  = wdata_q;
  assign io_be     = wbe_q;
  assign io_addr   = addr_q[IO_AW-1:0];

endmodule

// File: rtl/iobt_checker.sv
module iobt_checker #(
  parameter int IO_AW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_n,
  input logic             irdy_n,
  input logic [3:0]       cbe_n,
  input logic [31:0]      ad_out,
  input logic             ad_oe,
  input logic             trdy_n,
  input logic             devsel_n,
  input logic             stop_n,
  input logic             ctl_oe,
  input logic             par_out,
  input logic             par_oe,
  input logic             io_rd_stb,
  input logic             io_wr_stb,
  input logic [IO_AW-1:0] io_addr
);

  // R2: a claim only starts after an address clock holding one of the four commands
  p_claim_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_oe) |-> ($past(!frame_n) &&
      (($past(cbe_n[3:1]) == 3'b001) || ($past(cbe_n[3:1]) == 3'b101))));

  // R5: ready is only driven while the claim is held
  p_trdy_in_claim_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe && !trdy_n) |-> !devsel_n);

  // R5: the released-claim clock is followed by all enables off
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe && devsel_n) |=> (!ctl_oe && !ad_oe));

  // R6: a read word waiting on the initiator stays put
  p_wait_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && !trdy_n && irdy_n) |=> (!trdy_n && $stable(ad_out)));

  // R8: parity covers the previous clock's data and lanes
  p_par_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> (par_out == ^{$past(ad_out), $past(cbe_n)}));

  // R8: parity enable trails the data enable
  p_par_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_oe) |-> $past(ad_oe));

  // R9: stop is held until the initiator lets frame go
  p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe && !stop_n && trdy_n && !frame_n) |=> (!stop_n && !devsel_n));

  // R13: read strobe only in the wait clock of a claimed cycle
  p_rd_stb_r13: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd_stb |-> (ctl_oe && trdy_n && !devsel_n));

  // R13: write strobe follows a completed handshake
  p_wr_stb_r13: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr_stb |-> ($past(!irdy_n && !trdy_n && ctl_oe) && !$past(io_wr_stb)));

  // R13: the internal address does not move while the write strobe is out
  p_wr_addr_r13: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr_stb |-> $stable(io_addr));

endmodule

bind iobus_target iobt_checker #(.IO_AW(IO_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_n   (frame_n),
  .irdy_n    (irdy_n),
  .cbe_n     (cbe_n),
  .ad_out    (ad_out),
  .ad_oe     (ad_oe),
  .trdy_n    (trdy_n),
  .devsel_n  (devsel_n),
  .stop_n    (stop_n),
  .ctl_oe    (ctl_oe),
  .par_out   (par_out),
  .par_oe    (par_oe),
  .io_rd_stb (io_rd_stb),
  .io_wr_stb (io_wr_stb),
  .io_addr   (io_addr)
);

// File: tb/iobus_target_bench.sv
module iobus_target_bench;

  localparam logic [15:0] B_VEN   = 16'h1B2C;
  localparam logic [15:0] B_DEV   = 16'h0A51;
  localparam logic [23:0] B_CLASS = 24'h078000;
  localparam logic [7:0]  B_REV   = 8'h03;
  localparam logic [7:0]  B_PIN   = 8'h01;
  localparam int          B_AW    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
  logic [31:0] ad_in = 32'h0;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_out, io_wdata, io_rdata;
  logic ad_oe, trdy_n, devsel_n, stop_n, ctl_oe, par_out, par_oe;
  logic io_rd_stb, io_wr_stb;
  logic [B_AW-1:0] io_addr;
  logic [3:0] io_be;

  int checks = 0;
  int errors = 0;

  // Bench view of the writable header state.
  logic        m_io_en = 1'b0;
  logic [27:0] m_bar   = '0;
  logic [7:0]  m_line  = 8'h00;

  always #2.5 clk = ~clk;

  assign io_rdata = {16'h5A5A, 12'h000, io_addr};

  iobus_target #(
    .VEN_ID(B_VEN), .DEV_ID(B_DEV), .CLASS_CODE(B_CLASS),
    .REV_ID(B_REV), .INT_PIN(B_PIN), .IO_AW(B_AW)
  ) u_iobus_target (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .idsel(idsel), .ad_in(ad_in), .cbe_n(cbe_n), .ad_out(ad_out),
    .ad_oe(ad_oe), .trdy_n(trdy_n), .devsel_n(devsel_n), .stop_n(stop_n),
    .ctl_oe(ctl_oe), .par_out(par_out), .par_oe(par_oe),
    .io_rd_stb(io_rd_stb), .io_wr_stb(io_wr_stb), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_be(io_be), .io_rdata(io_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg_exp(input logic [5:0] idx);
    case (idx)
      6'h00:   return {B_DEV, B_VEN};
      6'h01:   return {31'h0, m_io_en};
      6'h02:   return {B_CLASS, B_REV};
      6'h04:   return {m_bar, 4'b0001};
      6'h0F:   return {16'h0, B_PIN, m_line};
      default: return 32'h0;
    endcase
  endfunction

  task automatic cfg_apply(input logic [5:0] idx, input logic [31:0] d, input logic [3:0] be);
    if (idx == 6'h01 && be[0]) m_io_en = d[0];
    if (idx == 6'h0F && be[0]) m_line = d[7:0];
    if (idx == 6'h04)
      for (int b = 4; b < 32; b++) if (be[b/8]) m_bar[b-4] = d[b];
  endtask

  // Address clock, then n data phases; waits = idle-initiator clocks per word.
  task automatic do_read(input bit io, input logic [31:0] addr, input int n, input int waits);
    logic [31:0] exp;
    logic [5:0]  idx;
    exp = 32'h0;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr;
    cbe_n = io ? 4'b0010 : 4'b1010; idsel = !io;
    for (int i = 0; i < n; i++) begin
      idx = addr[7:2] + 6'(i);
      exp = io ? {16'h5A5A, 12'h000, addr[3:0]} : cfg_exp(idx);
      @(negedge clk);
      chk(ctl_oe && !devsel_n && trdy_n, "R7 wait clock before read word", {devsel_n, trdy_n}, 2'b01);
      chk(ad_oe == (i > 0), "R7 data enable in wait clock", ad_oe, (i > 0));
      if (io) chk(io_rd_stb && io_addr == addr[3:0], "R13 read strobe and byte address",
                  {io_rd_stb, io_addr}, {1'b1, addr[3:0]});
      ad_in = 32'hDEAD_BEEF; cbe_n = 4'b0000; idsel = 1'b0;
      irdy_n = (waits == 0) ? 1'b0 : 1'b1;
      frame_n = (waits == 0 && i == n - 1) ? 1'b1 : 1'b0;
      @(negedge clk);
      chk(!trdy_n && ad_oe && ad_out == exp, io ? "R13 read word" : "R11 read word", ad_out, exp);
      chk(stop_n == !io, io ? "R9 stop with io word" : "R10 no stop on config", stop_n, !io);
      for (int w = 0; w < waits; w++) begin
        @(negedge clk);
        chk(!trdy_n && ad_out == exp, "R6 word held during initiator wait", ad_out, exp);
      end
      if (waits > 0) begin irdy_n = 1'b0; frame_n = (i == n - 1); end
      if (io && n > 1) begin
        @(negedge clk);
        chk(!stop_n && trdy_n && !devsel_n, "R9 stop held while frame low",
            {stop_n, trdy_n, devsel_n}, 3'b010);
        @(negedge clk);
        chk(!stop_n && trdy_n, "R9 stop still held", {stop_n, trdy_n}, 2'b01);
        frame_n = 1'b1;
        break;
      end
    end
    @(negedge clk);
    chk(ctl_oe && devsel_n && trdy_n, "R5 claim released after final phase", {ctl_oe, devsel_n, trdy_n}, 3'b111);
    chk(par_oe && par_out == ^exp, "R8 parity of final word", {par_oe, par_out}, {1'b1, ^exp});
    irdy_n = 1'b1; frame_n = 1'b1;
    @(negedge clk);
    chk(!ctl_oe && !ad_oe, "R5 enables off", {ctl_oe, ad_oe}, 2'b00);
  endtask

  task automatic do_write(input bit io, input logic [31:0] addr, input int n, input int waits,
                          input logic [31:0] d0, input logic [31:0] d1, input logic [3:0] be);
    logic [31:0] d;
    logic [5:0]  idx;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr;
    cbe_n = io ? 4'b0011 : 4'b1011; idsel = !io;
    for (int i = 0; i < n; i++) begin
      d = (i == 0) ? d0 : d1;
      idx = addr[7:2] + 6'(i);
      @(negedge clk);
      chk(!trdy_n && !devsel_n && !ad_oe, "R5 write data phase claimed", {trdy_n, devsel_n, ad_oe}, 3'b000);
      chk(stop_n == !io, io ? "R9 stop with io word" : "R10 no stop on config", stop_n, !io);
      ad_in = d; cbe_n = ~be; idsel = 1'b0;
      irdy_n = (waits == 0) ? 1'b0 : 1'b1;
      frame_n = (waits == 0 && i == n - 1) ? 1'b1 : 1'b0;
      for (int w = 0; w < waits; w++) begin
        @(negedge clk);
        chk(!trdy_n && !io_wr_stb, "R6 no transfer while initiator waits", {trdy_n, io_wr_stb}, 2'b00);
        if (w == waits - 1) begin irdy_n = 1'b0; frame_n = (i == n - 1); end
      end
      if (!io) cfg_apply(idx, d, be);
      if (io) begin
        @(negedge clk);
        chk(io_wr_stb && io_wdata == d && io_be == be && io_addr == addr[3:0],
            "R13 write strobe contents", io_wdata, d);
        if (n > 1) begin
          chk(!stop_n && trdy_n && !devsel_n, "R9 stop held after io write",
              {stop_n, trdy_n, devsel_n}, 3'b010);
          frame_n = 1'b1;
          @(negedge clk);
          chk(!io_wr_stb, "R13 single write strobe", io_wr_stb, 1'b0);
        end
        break;
      end
    end
    if (!io) @(negedge clk);
    chk(ctl_oe && devsel_n && trdy_n, "R5 claim released after write", {ctl_oe, devsel_n, trdy_n}, 3'b111);
    irdy_n = 1'b1; frame_n = 1'b1;
    @(negedge clk);
    chk(!ctl_oe && !io_wr_stb, "R5 enables off after write", {ctl_oe, io_wr_stb}, 2'b00);
  endtask

  // A cycle that must not be claimed; mid-cycle it shows a valid config command.
  task automatic no_claim(input logic [3:0] cmd, input logic [31:0] addr, input logic sel, input string tag);
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd; idsel = sel;
    @(negedge clk);
    chk(!ctl_oe, tag, ctl_oe, 1'b0);
    ad_in = 32'h0000_0000; cbe_n = 4'b1010; idsel = 1'b1; irdy_n = 1'b0;
    @(negedge clk);
    chk(!ctl_oe, "R1 mid-cycle command ignored", ctl_oe, 1'b0);
    frame_n = 1'b1;
    @(negedge clk);
    chk(!ctl_oe, "R1 mid-cycle command ignored", ctl_oe, 1'b0);
    irdy_n = 1'b1; idsel = 1'b0; cbe_n = 4'hF;
    @(negedge clk);
    chk(!ctl_oe && !io_rd_stb && !io_wr_stb, tag, {ctl_oe, io_rd_stb, io_wr_stb}, 3'b000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ctl_oe && !ad_oe && !par_oe && !io_rd_stb && !io_wr_stb, "R5 reset state",
        {ctl_oe, ad_oe, par_oe, io_rd_stb, io_wr_stb}, 5'b0);

    // Header contents after reset.
    do_read(1'b0, 32'h0000_0000, 1, 0);
    do_read(1'b0, 32'h0000_0008, 1, 1);
    do_read(1'b0, 32'h0000_003C, 1, 0);
    do_read(1'b0, 32'h0000_0010, 1, 0);
    do_read(1'b0, 32'h0000_0014, 1, 0);

    // R3: no I/O claim while disabled.
    no_claim(4'b0010, 32'h0000_0000, 1'b0, "R3 io disabled not claimed");

    // R12: lane-qualified writes, read-only fields.
    do_write(1'b0, 32'h0000_0004, 1, 0, 32'hFFFF_FFFF, 32'h0, 4'b0010);
    do_read(1'b0, 32'h0000_0004, 1, 0);
    do_write(1'b0, 32'h0000_0004, 1, 2, 32'h0000_0001, 32'h0, 4'b0001);
    do_read(1'b0, 32'h0000_0004, 1, 0);
    do_write(1'b0, 32'h0000_0000, 1, 0, 32'hFFFF_FFFF, 32'h0, 4'b1111);
    do_write(1'b0, 32'h0000_0008, 1, 0, 32'h1234_5678, 32'h0, 4'b1111);
    do_read(1'b0, 32'h0000_0000, 1, 0);
    do_read(1'b0, 32'h0000_0008, 1, 0);
    do_write(1'b0, 32'h0000_0010, 1, 0, 32'h0000_C3F7, 32'h0, 4'b1111);
    do_read(1'b0, 32'h0000_0010, 1, 0);
    do_write(1'b0, 32'h0000_0010, 1, 0, 32'hAAAA_1100, 32'h0, 4'b0100);
    do_read(1'b0, 32'h0000_0010, 1, 0);
    do_write(1'b0, 32'h0000_0010, 1, 0, 32'h0000_C3F0, 32'h0, 4'b1111);

    // R10: config bursts.
    do_read(1'b0, 32'h0000_0000, 3, 2);
    do_write(1'b0, 32'h0000_0038, 2, 1, 32'hFFFF_FFFF, 32'h0000_770B, 4'b0001);
    do_read(1'b0, 32'h0000_0038, 2, 0);

    // I/O window traffic.
    do_write(1'b1, 32'h0000_C3F3, 1, 0, 32'hCAFE_0042, 32'h0, 4'b1000);
    do_read(1'b1, 32'h0000_C3F6, 1, 2);
    do_read(1'b1, 32'h0000_C3F1, 2, 0);
    do_write(1'b1, 32'h0000_C3FE, 2, 1, 32'h0BAD_F00D, 32'h0, 4'b0110);
    no_claim(4'b0011, 32'h0000_C400, 1'b0, "R3 io outside window not claimed");

    // R2 and R4: not claimed.
    no_claim(4'b0110, 32'h0000_0000, 1'b1, "R2 memory read not claimed");
    no_claim(4'b1000, 32'h0000_C3F0, 1'b1, "R2 reserved code not claimed");
    no_claim(4'b1010, 32'h0000_0000, 1'b0, "R4 config without select not claimed");
    no_claim(4'b1010, 32'h0000_0001, 1'b1, "R4 config with nonzero low bits not claimed");

    // Still answering after all of the above.
    do_read(1'b0, 32'h0000_003C, 1, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule